// File: doc/BRIEF.md
# Buffered Compare Channel for an 8-bit Timer

This block is one compare channel of an 8-bit timer. It keeps an active compare value and checks it for equality against the live count on every timer tick. On a tick where the two are equal, it raises a one-cycle match pulse and a sticky compare flag. When the flag is set and the channel's mask bit is 1, it requests an interrupt. The timer core supplies the count, the tick enable, the TOP and BOTTOM strobes and the waveform mode. A CPU-side bus adapter supplies the write strobes. Pin waveform logic sits outside this block and consumes the match pulse.

In the two PWM modes, a CPU write to the compare value lands in a buffer. The active value is refreshed from the buffer only on the tick at the sequence boundary, so a pulse never changes length in the middle of a period. In the two non-PWM modes, the write reaches the active value directly. A write to the counter sets a block that removes the match from the next timer tick. The block holds even while the timer is stopped, so the compare value can be set equal to the counter without a spurious flag.

Top module: `cmp_channel`

## Requirements
- R1: After a synchronous active-low reset, the active compare value, the buffered compare value, the flag and the mask are all 0, and `irq` is low.
- R2: `match` is high in exactly the cycles where `tick` is 1, `count` equals `cmp_active`, and no counter-write block is pending.
- R3: The flag becomes 1 at the clock edge that ends a match cycle. It then stays 1 until it is cleared. A match in the same cycle as a clear leaves the flag at 1.
- R4: A cycle with `flag_clr` = 1 (CPU write of one) or `int_ack` = 1 (interrupt serviced) clears the flag at that edge, provided no match occurs in that cycle.
- R5: `mask` takes `mask_data` on a `wr_mask` cycle. `irq` is 1 exactly while both flag and mask are 1.
- R6: With `mode` = 0 (normal) or 1 (clear on match), a `wr_cmp` cycle loads `wr_data` into both `cmp_active` and `cmp_buffer`, visible in the next cycle.
- R7: With `mode` = 2 (fast PWM) or 3 (phase-correct PWM), a `wr_cmp` cycle loads only `cmp_buffer`. `cmp_active` takes `cmp_buffer` only at an edge where `tick` = 1 and the load strobe is 1. The load strobe is `at_top` by default, or `at_bottom` when `LOAD_AT_BOTTOM` = 1.
- R8: A cycle with `wr_cnt` = 1 suppresses the match on the next cycle with `tick` = 1, however many tickless cycles pass in between. Matches on later ticks are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| count | input | CNT_W | Live counter value |
| tick | input | 1 | Timer clock enable; the counter advances at this edge |
| at_top | input | 1 | Counter holds its TOP value |
| at_bottom | input | 1 | Counter holds zero |
| mode | input | 2 | 0 normal, 1 clear on match, 2 fast PWM, 3 phase-correct PWM |
| wr_cmp | input | 1 | CPU write of the compare value |
| wr_data | input | CNT_W | Compare value to write |
| wr_cnt | input | 1 | CPU write to the counter took place |
| flag_clr | input | 1 | CPU wrote one to the flag |
| int_ack | input | 1 | Interrupt for this flag is being serviced |
| wr_mask | input | 1 | CPU write of the mask bit |
| mask_data | input | 1 | Mask value to write |
| cmp_active | output | CNT_W | Compare value in use |
| cmp_buffer | output | CNT_W | Buffered compare value |
| match | output | 1 | Compare match pulse |
| flag | output | 1 | Sticky compare flag |
| irq | output | 1 | Interrupt request |

## Verification
The comparator is swept over compare values spread across the whole 8-bit range. For each value, the count runs through every value from 0 to 255. This tests that exactly one match occurs per sweep and that it lands at the right count, which separates a correct equality test from off-by-one or stuck comparisons.

Buffered writes are tried with ticks off the boundary, with the boundary strobe but no tick, and with both present. This separates the boundary-synchronized load from immediate and tick-only loads.

Counter writes are followed by a running tick, and separately by a stopped stretch before the tick. Each case is followed by a second equal tick, which shows that the block removes exactly one match.

Clear, acknowledge, mask and same-cycle set-versus-clear patterns isolate the flag priorities.

// File: rtl/cmp_channel_pkg.sv
// Shared types for the timer compare channel.
// Assumes the 2-bit mode encoding listed in the brief.
package cmp_channel_pkg;

    typedef enum logic [1:0] {
        WAVE_NORMAL = 2'd0,
        WAVE_CTC    = 2'd1,
        WAVE_FAST   = 2'd2,
        WAVE_PHASE  = 2'd3
    } wave_mode_e;

    // True for the modes whose compare writes are buffered
    function automatic logic mode_is_pwm(input wave_mode_e m);
        return (m == WAVE_FAST) || (m == WAVE_PHASE);
    endfunction

endpackage

// File: rtl/cmp_value_store.sv
// Active and buffered compare registers.
// In PWM modes, writes fill the buffer. The active value is refreshed
// on the tick at the selected sequence boundary. Otherwise writes
// update both registers at once.
// Assumes the boundary strobes are valid in the tick cycle of that count.
module cmp_value_store
    import cmp_channel_pkg::*;
#(
    parameter int CNT_W          = 8,
    parameter bit LOAD_AT_BOTTOM = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wave_mode_e       mode,
    input  logic             wr_cmp,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             tick,
    input  logic             at_top,
    input  logic             at_bottom,
    output logic [CNT_W-1:0] cmp_active,
    output logic [CNT_W-1:0] cmp_buffer
);

    logic edge_strobe;
    logic pwm_on;
    logic load_now;

    // Pick which sequence boundary releases the buffer
    generate
        if (LOAD_AT_BOTTOM) begin : g_bottom
            assign edge_strobe = at_bottom;
        end else begin : g_top
            assign edge_strobe = at_top;
        end
    endgenerate

    assign pwm_on   = mode_is_pwm(mode);
    assign load_now = pwm_on && tick && edge_strobe;

    // Buffer register: follows every CPU write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_buffer <= '0;
        end else if (wr_cmp) begin
            cmp_buffer <= wr_data;
        end
    end

    // Active register: direct write or boundary transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_active <= '0;
        end else if (wr_cmp && !pwm_on) begin
            cmp_active <= wr_data;
        end else if (load_now) begin
            cmp_active <= cmp_buffer;
        end
    end

    // R6
    direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmp && !pwm_on) |=> (cmp_active == $past(wr_data)));

    // R7
    buffered_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_on && !(tick && edge_strobe)) |=> $stable(cmp_active));

endmodule

// File: rtl/cmp_match_gate.sv
// Equality comparator with counter-write blocking.
// A counter write arms a block. The block removes the match on the next
// tick, then clears itself. Assumes count is stable through each tick cycle.
module cmp_match_gate #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp_active,
    input  logic             tick,
    input  logic             wr_cnt,
    output logic             match
);

    logic block_q;
    logic equal;

    assign equal = (count == cmp_active);
    assign match = tick && equal && !block_q;

    // Block flag: armed by a counter write, spent by the next tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            block_q <= 1'b0;
        end else if (wr_cnt) begin
            block_q <= 1'b1;
        end else if (tick) begin
            block_q <= 1'b0;
        end
    end

    // R8
    block_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_cnt) |-> !match);

    // R2
    match_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> (tick && (count == cmp_active)));

endmodule

// File: rtl/cmp_flag_ctl.sv
// Sticky compare flag, mask bit and interrupt request.
// A match sets the flag and wins over a clear in the same cycle.
// Assumes the clear and acknowledge inputs are single-cycle strobes.
module cmp_flag_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    input  logic flag_clr,
    input  logic int_ack,
    input  logic wr_mask,
    input  logic mask_data,
    output logic flag,
    output logic mask,
    output logic irq
);

    // Flag register: set by match, cleared by CPU or service
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (match) begin
            flag <= 1'b1;
        end else if (flag_clr || int_ack) begin
            flag <= 1'b0;
        end
    end

    // Mask register: written by the CPU
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= 1'b0;
        end else if (wr_mask) begin
            mask <= mask_data;
        end
    end

    assign irq = flag && mask;

    // R3
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> flag);

    // R3
    flag_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(match));

    // R4
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_clr || int_ack) && !match) |=> !flag);

endmodule

// File: rtl/cmp_channel.sv
// One compare channel of an 8-bit timer: compare registers, gated
// comparator, and flag/interrupt logic.
// Assumes the timer core drives count, tick and the boundary strobes
// from one clock domain.
module cmp_channel
    import cmp_channel_pkg::*;
#(
    parameter int CNT_W          = 8,
    parameter bit LOAD_AT_BOTTOM = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic             tick,
    input  logic             at_top,
    input  logic             at_bottom,
    input  logic [1:0]       mode,
    input  logic             wr_cmp,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             wr_cnt,
    input  logic             flag_clr,
    input  logic             int_ack,
    input  logic             wr_mask,
    input  logic             mask_data,
    output logic [CNT_W-1:0] cmp_active,
    output logic [CNT_W-1:0] cmp_buffer,
    output logic             match,
    output logic             flag,
    output logic             irq
);

    wave_mode_e mode_e;
    logic       mask_q;

    assign mode_e = wave_mode_e'(mode);

    cmp_value_store #(
        .CNT_W          (CNT_W),
        .LOAD_AT_BOTTOM (LOAD_AT_BOTTOM)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode_e),
        .wr_cmp     (wr_cmp),
        .wr_data    (wr_data),
        .tick       (tick),
        .at_top     (at_top),
        .at_bottom  (at_bottom),
        .cmp_active (cmp_active),
        .cmp_buffer (cmp_buffer)
    );

    cmp_match_gate #(
        .CNT_W (CNT_W)
    ) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .count      (count),
        .cmp_active (cmp_active),
        .tick       (tick),
        .wr_cnt     (wr_cnt),
        .match      (match)
    );

    cmp_flag_ctl u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .match     (match),
        .flag_clr  (flag_clr),
        .int_ack   (int_ack),
        .wr_mask   (wr_mask),
        .mask_data (mask_data),
        .flag      (flag),
        .mask      (mask_q),
        .irq       (irq)
    );

    // R5
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && mask_q));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!flag && !irq && cmp_active == '0 && cmp_buffer == '0));

endmodule

// File: tb/tb_cmp_channel.sv
module tb_cmp_channel;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] count = '0;
    logic       tick = 1'b0, at_top = 1'b0, at_bottom = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       wr_cmp = 1'b0, wr_cnt = 1'b0, flag_clr = 1'b0, int_ack = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_mask = 1'b0, mask_data = 1'b0;
    logic [7:0] cmp_active, cmp_buffer;
    logic       match, flag, irq;

    int checks = 0;
    int failures = 0;
    int cyc_cnt = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cmp_channel dut (
        .clk(clk), .rst_n(rst_n), .count(count), .tick(tick),
        .at_top(at_top), .at_bottom(at_bottom), .mode(mode),
        .wr_cmp(wr_cmp), .wr_data(wr_data), .wr_cnt(wr_cnt),
        .flag_clr(flag_clr), .int_ack(int_ack), .wr_mask(wr_mask),
        .mask_data(mask_data), .cmp_active(cmp_active),
        .cmp_buffer(cmp_buffer), .match(match), .flag(flag), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle: inputs held from just after a negedge, comb sampled at +2
    task automatic cycle(input logic [7:0] c, input logic t, input logic top,
                         output logic m);
        count = c; tick = t; at_top = top;
        #2 m = match;
        @(negedge clk);
        tick = 0; at_top = 0; wr_cmp = 0; wr_cnt = 0;
        flag_clr = 0; int_ack = 0; wr_mask = 0;
    endtask

    task automatic write_cmp(input logic [7:0] v);
        logic m;
        wr_cmp = 1; wr_data = v;
        cycle(count, 0, 0, m);
    endtask

    task automatic clear_flag();
        logic m;
        flag_clr = 1;
        cycle(count, 0, 0, m);
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 150000 && !done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=0", cyc_cnt);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic m;
        int hits, pos;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check("R1 active", cmp_active, 0);
        check("R1 buffer", cmp_buffer, 0);
        check("R1 flag", flag, 0);
        check("R1 irq", irq, 0);

        // R6 direct write in normal and clear-on-match modes
        mode = 2'd0;
        write_cmp(8'd77);
        check("R6 normal active", cmp_active, 77);
        check("R6 normal buffer", cmp_buffer, 77);
        mode = 2'd1;
        write_cmp(8'd12);
        check("R6 ctc active", cmp_active, 12);

        // R2/R3 sweep: one match per full count pass, at the compare value
        mode = 2'd0;
        for (int v = 0; v < 256; v += 15) begin
            write_cmp(v[7:0]);
            clear_flag();
            hits = 0; pos = -1;
            for (int c = 0; c < 256; c++) begin
                cycle(c[7:0], 1, 0, m);
                if (m) begin hits++; pos = c; end
                if (c == v) check("R3 flag after match", flag, 1);
            end
            check("R2 match count", hits, 1);
            check("R2 match position", pos, v);
        end
        // R2 compare value 255
        write_cmp(8'd255);
        clear_flag();
        hits = 0;
        for (int c = 0; c < 256; c++) begin
            cycle(c[7:0], 1, 0, m);
            if (m) hits++;
        end
        check("R2 match at max", hits, 1);
        // R2 equality without tick gives no match
        cycle(8'd255, 0, 0, m);
        check("R2 no tick no match", m, 0);

        // R4 CPU clear and service clear; R3 stickiness
        write_cmp(8'd40);
        cycle(8'd40, 1, 0, m);
        cycle(8'd41, 0, 0, m);
        check("R3 flag sticky", flag, 1);
        clear_flag();
        check("R4 clear by write", flag, 0);
        cycle(8'd40, 1, 0, m);
        int_ack = 1;
        cycle(8'd41, 0, 0, m);
        check("R4 clear by service", flag, 0);
        // R3 match wins over simultaneous clear
        flag_clr = 1;
        cycle(8'd40, 1, 0, m);
        check("R3 set beats clear", flag, 1);

        // R5 mask gating
        check("R5 masked irq", irq, 0);
        wr_mask = 1; mask_data = 1;
        cycle(8'd0, 0, 0, m);
        check("R5 unmasked irq", irq, 1);
        clear_flag();
        check("R5 irq drops with flag", irq, 0);

        // R8 block while running
        cycle(8'd40, 0, 0, m);
        wr_cnt = 1;
        cycle(8'd40, 0, 0, m);
        cycle(8'd40, 1, 0, m);
        check("R8 running block", m, 0);
        cycle(8'd40, 1, 0, m);
        check("R8 block released", m, 1);
        // R8 block while stopped
        wr_cnt = 1;
        cycle(8'd40, 0, 0, m);
        for (int i = 0; i < 6; i++) cycle(8'd40, 0, 0, m);
        cycle(8'd40, 1, 0, m);
        check("R8 stopped block", m, 0);
        cycle(8'd40, 1, 0, m);
        check("R8 stopped release", m, 1);

        // R7 buffered writes in fast PWM
        mode = 2'd2;
        write_cmp(8'd99);
        check("R7 fast buffer", cmp_buffer, 99);
        check("R7 fast active held", cmp_active, 40);
        cycle(8'd10, 1, 0, m);
        check("R7 tick off boundary", cmp_active, 40);
        cycle(8'd255, 0, 1, m);
        check("R7 strobe without tick", cmp_active, 40);
        cycle(8'd255, 1, 1, m);
        check("R7 fast load at top", cmp_active, 99);
        // R7 phase-correct
        mode = 2'd3;
        write_cmp(8'd7);
        check("R7 phase active held", cmp_active, 99);
        cycle(8'd255, 1, 1, m);
        check("R7 phase load at top", cmp_active, 7);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule